// File: doc/BRIEF.md
# Doorbell Write-Capture Queue

The block turns host writes that land in a write-only doorbell window into records appended to circular queues in local memory. Each captured write produces an 8-byte record: a 32-bit word holding the write address, then a 32-bit word holding the write data. Software on the local processor consumes the records, and a one-cycle wake pulse tells it that a new record has been written.

The window can feed a single queue, or it can be split into four queues, each serving one 2 MB slice. Queue size is programmable from 512 to 64K entries. An optional credit check throttles each 4 KB page of the window. A limit/count byte pair for that page, held in the last 4 KB of local memory, is read and compared. If credit remains, the count is updated by a byte write. If none remains, the doorbell is dropped. Host writes pass through a small input buffer that stalls the host while the memory sequence runs.

Top module: `doorbell_capture`

## Requirements
- R1: A host write is captured only if its 24-bit byte offset lies in 0x808000..0xFFFFFF. Any other write is accepted and then dropped, with no memory access and no wake pulse.
- R2: A captured write produces two full-word memory writes (mem_be_o=4'hF), in this order. The first goes to the record base and holds the address {8'h00, offset[23:2], 2'b00}. The second goes to the record base + 4 and holds the data.
- R3: The record base is base + 8*index. Each queue's index starts at 0, advances by one per record and wraps modulo 512<<cfg_size_i.
- R4: With cfg_multi_i=1, offset[22:21] selects queue 0..3, and each queue has its own base (base_i[q*MEM_AW +: MEM_AW]) and its own index. With cfg_multi_i=0, every captured write goes to queue 0.
- R5: With cfg_limit_i=1, the block first reads the word at ((0x7FF000 + 2*page) & ~3), where page = offset[22:12]. In that word, byte lane k is bits [8k+7:8k]. The limit is in lane 2*page[0] and the count is in lane 2*page[0]+1.
- R6: If count != limit, the block writes count+1 into the count lane (mem_be_o one-hot on that lane). This write comes before the two record writes, and a wake pulse follows.
- R7: If count == limit, the doorbell is dropped: there is no write of any kind and no wake pulse.
- R8: wake_o pulses for one cycle, in the same cycle as the data word write of each record, and at no other time.
- R9: A cfg_we_i pulse clears every queue index to 0.
- R10: The input buffer holds up to DEPTH writes. hw_ready_o goes low when the buffer is full. Accepted writes are handled in order and none are lost.
- R11: After reset, hw_ready_o is 1, and mem_req_o and wake_o are 0. Read data is valid on mem_rdata_i in the cycle after a read request (mem_req_o=1, mem_we_o=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_valid_i | input | 1 | Host write valid |
| hw_ready_o | output | 1 | Input buffer can accept |
| hw_addr_i | input | 24 | Host byte offset |
| hw_data_i | input | 32 | Host write data |
| cfg_we_i | input | 1 | Configuration rewritten; clears indices |
| cfg_size_i | input | 3 | Queue size select (512<<n entries) |
| cfg_multi_i | input | 1 | Four-queue mode |
| cfg_limit_i | input | 1 | Per-page credit check enable |
| base_i | input | 4*MEM_AW | Queue base pointers, queue q at [q*MEM_AW +: MEM_AW] |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | MEM_AW | Memory byte address, word aligned |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read |
| wake_o | output | 1 | New-record pulse |

## Verification
A corrupted queue index shows up as a record written to the wrong base. The write-address stream diverges on the very next doorbell to that queue, or only after 512<<size records if the fault lies in the wrap mask. A stale or mis-laned credit byte shows up as an extra or missing count write, or a count value that is off, within three cycles of the doorbell being dequeued. A dropped or duplicated buffer entry changes the order of the record stream. The scoreboard therefore compares every memory write and every wake pulse in order against a model kept in the bench.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CMP, S_WCNT, S_WADDR, S_WDATA
  } db_state_e;
endpackage

// File: rtl/db_fifo.sv
module db_fifo #(
  parameter int W     = 56,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] rdata_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= inc(wp_q);
      if (pop_i)  rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/db_decode.sv
module db_decode #(
  parameter int HOST_AW = 24,
  parameter int NQ      = 4
) (
  input  logic [HOST_AW-1:0]  off_i,
  input  logic                multi_i,
  output logic                hit_o,
  output logic [$clog2(NQ)-1:0] q_o,
  output logic [HOST_AW-14:0] page_o,
  output logic [31:0]         saddr_o
);
  localparam int QW = $clog2(NQ);
  localparam logic [HOST_AW-1:0] WIN_LO = HOST_AW'((1 << (HOST_AW - 1)) + 32'h8000);

  assign hit_o   = (off_i >= WIN_LO);
  assign q_o     = multi_i ? off_i[HOST_AW-2 -: QW] : '0;
  assign page_o  = off_i[HOST_AW-2:12];
  assign saddr_o = 32'({off_i[HOST_AW-1:2], 2'b00});
endmodule

// File: rtl/db_engine.sv
module db_engine
  import db_pkg::*;
#(
  parameter int HOST_AW = 24,
  parameter int MEM_AW  = 23,
  parameter int NQ      = 4,
  parameter int MAXSEL  = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 empty_i,
  output logic                 pop_o,
  input  logic                 hit_i,
  input  logic [$clog2(NQ)-1:0] q_i,
  input  logic [HOST_AW-14:0]  page_i,
  input  logic [31:0]          saddr_i,
  input  logic [31:0]          data_i,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_size_i,
  input  logic                 cfg_limit_i,
  input  logic [NQ*MEM_AW-1:0] base_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [MEM_AW-1:0]    mem_addr_o,
  output logic [3:0]           mem_be_o,
  output logic [31:0]          mem_wdata_o,
  input  logic [31:0]          mem_rdata_i,
  output logic                 wake_o
);
  localparam int QW     = $clog2(NQ);
  localparam int PGW    = HOST_AW - 13;
  localparam int IDX_W  = 9 + MAXSEL;
  localparam logic [MEM_AW-1:0] PAIR_TOP = MEM_AW'((64'd1 << MEM_AW) - 64'd4096);

  db_state_e         st_q;
  logic [31:0]       saddr_q, data_q;
  logic [QW-1:0]     q_q;
  logic [PGW-1:0]    page_q;
  logic [7:0]        cnt_nxt_q;
  logic [IDX_W-1:0]  idx_q [NQ];
  logic [IDX_W-1:0]  mask, idx_sel;
  logic [MEM_AW-1:0] base_sel, rec_base, pair_addr;
  logic [7:0]        lim_b, cnt_b;

  assign mask      = IDX_W'(((IDX_W+1)'(512) << cfg_size_i) - 1'b1);
  assign idx_sel   = idx_q[q_q];
  assign base_sel  = base_i[q_q*MEM_AW +: MEM_AW];
  assign rec_base  = base_sel + (MEM_AW'(idx_sel) << 3);
  assign pair_addr = (PAIR_TOP + MEM_AW'({page_q, 1'b0})) & ~MEM_AW'(3);
  assign lim_b     = page_q[0] ? mem_rdata_i[23:16] : mem_rdata_i[7:0];
  assign cnt_b     = page_q[0] ? mem_rdata_i[31:24] : mem_rdata_i[15:8];
  assign pop_o     = (st_q == S_IDLE) && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      saddr_q   <= '0;
      data_q    <= '0;
      q_q       <= '0;
      page_q    <= '0;
      cnt_nxt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (!empty_i && hit_i) begin
          saddr_q <= saddr_i;
          data_q  <= data_i;
          q_q     <= q_i;
          page_q  <= page_i;
          st_q    <= cfg_limit_i ? S_RD : S_WADDR;
        end
        S_RD:   st_q <= S_CMP;
        S_CMP: begin
          cnt_nxt_q <= cnt_b + 8'd1;
          st_q      <= (cnt_b == lim_b) ? S_IDLE : S_WCNT;
        end
        S_WCNT:  st_q <= S_WADDR;
        S_WADDR: st_q <= S_WDATA;
        S_WDATA: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_idx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    idx_q[g] <= '0;
      else if (cfg_we_i)                              idx_q[g] <= '0;
      else if (st_q == S_WDATA && q_q == QW'(g))      idx_q[g] <= (idx_q[g] + 1'b1) & mask;
    end

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_we_i) |-> idx_q[g] == '0);
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 4'h0;
    mem_wdata_o = '0;
    wake_o      = 1'b0;
    unique case (st_q)
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pair_addr;
        mem_be_o   = 4'hF;
      end
      S_WCNT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pair_addr;
        mem_be_o    = page_q[0] ? 4'b1000 : 4'b0010;
        mem_wdata_o = {4{cnt_nxt_q}};
      end
      S_WADDR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = rec_base;
        mem_be_o    = 4'hF;
        mem_wdata_o = saddr_q;
      end
      S_WDATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = rec_base + MEM_AW'(4);
        mem_be_o    = 4'hF;
        mem_wdata_o = data_q;
        wake_o      = 1'b1;
      end
      default: ;
    endcase
  end

  p_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  p_rec_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(mem_req_o && mem_we_o && mem_be_o == 4'hF) &&
               $past(mem_wdata_o[31:24]) == 8'h00 && $past(mem_wdata_o[1:0]) == 2'b00 &&
               mem_addr_o == $past(mem_addr_o) + MEM_AW'(4));
  p_read_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $countones(mem_be_o) == 1) |-> $past(mem_req_o && !mem_we_o, 2));
  p_cnt_then_rec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $countones(mem_be_o) == 1) |=> mem_we_o && mem_be_o == 4'hF && !wake_o);
  p_wake_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: rtl/doorbell_capture.sv
module doorbell_capture #(
  parameter int HOST_AW = 24,
  parameter int MEM_AW  = 23,
  parameter int NQ      = 4,
  parameter int DEPTH   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hw_valid_i,
  output logic                 hw_ready_o,
  input  logic [HOST_AW-1:0]   hw_addr_i,
  input  logic [31:0]          hw_data_i,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_size_i,
  input  logic                 cfg_multi_i,
  input  logic                 cfg_limit_i,
  input  logic [NQ*MEM_AW-1:0] base_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [MEM_AW-1:0]    mem_addr_o,
  output logic [3:0]           mem_be_o,
  output logic [31:0]          mem_wdata_o,
  input  logic [31:0]          mem_rdata_i,
  output logic                 wake_o
);
  localparam int QW = $clog2(NQ);
  localparam int FW = HOST_AW + 32;

  logic          full, empty, pop, push, hit;
  logic [FW-1:0] head;
  logic [QW-1:0] q;
  logic [HOST_AW-14:0] page;
  logic [31:0]   saddr;

  assign hw_ready_o = !full;
  assign push       = hw_valid_i && !full;

  db_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .wdata_i({hw_addr_i, hw_data_i}),
    .full_o (full),
    .pop_i  (pop),
    .empty_o(empty),
    .rdata_o(head)
  );

  db_decode #(.HOST_AW(HOST_AW), .NQ(NQ)) u_dec (
    .off_i  (head[FW-1:32]),
    .multi_i(cfg_multi_i),
    .hit_o  (hit),
    .q_o    (q),
    .page_o (page),
    .saddr_o(saddr)
  );

  db_engine #(.HOST_AW(HOST_AW), .MEM_AW(MEM_AW), .NQ(NQ)) u_eng (
    .clk_i, .rst_ni,
    .empty_i    (empty),
    .pop_o      (pop),
    .hit_i      (hit),
    .q_i        (q),
    .page_i     (page),
    .saddr_i    (saddr),
    .data_i     (head[31:0]),
    .cfg_we_i,
    .cfg_size_i,
    .cfg_limit_i,
    .base_i,
    .mem_req_o,
    .mem_we_o,
    .mem_addr_o,
    .mem_be_o,
    .mem_wdata_o,
    .mem_rdata_i,
    .wake_o
  );

  p_miss_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !hit) |=> !mem_req_o);
endmodule

// File: tb/doorbell_capture_bench.sv
module doorbell_capture_bench;
  localparam int MEM_AW = 23;
  localparam int NQ     = 4;
  localparam int DEPTH  = 2;
  localparam logic [MEM_AW-1:0] TOP = 23'h7FF000;

  logic clk = 0, rst_n = 0;
  logic hw_valid = 0, hw_ready;
  logic [23:0] hw_addr = '0;
  logic [31:0] hw_data = '0;
  logic cfg_we = 0, cfg_multi = 0, cfg_limit = 0;
  logic [2:0] cfg_size = '0;
  logic [NQ*MEM_AW-1:0] base = '0;
  logic mem_req, mem_we, wake;
  logic [MEM_AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;

  always #5 clk = ~clk;

  doorbell_capture u_doorbell_capture (
    .clk_i(clk), .rst_ni(rst_n),
    .hw_valid_i(hw_valid), .hw_ready_o(hw_ready), .hw_addr_i(hw_addr), .hw_data_i(hw_data),
    .cfg_we_i(cfg_we), .cfg_size_i(cfg_size), .cfg_multi_i(cfg_multi), .cfg_limit_i(cfg_limit),
    .base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .wake_o(wake)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] bmem [int unsigned];

  always @(posedge clk) begin
    if (mem_req && !mem_we)
      mem_rdata <= bmem.exists(32'(mem_addr >> 2)) ? bmem[32'(mem_addr >> 2)] : 32'h0;
    if (mem_req && mem_we) begin
      logic [31:0] w;
      w = bmem.exists(32'(mem_addr >> 2)) ? bmem[32'(mem_addr >> 2)] : 32'h0;
      for (int k = 0; k < 4; k++) if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
      bmem[32'(mem_addr >> 2)] = w;
    end
  end

  typedef struct {
    logic [MEM_AW-1:0] addr;
    logic [3:0]        be;
    logic [31:0]       data;
    logic              wk;
    string             tag;
  } exp_t;
  exp_t exp_q [$];

  logic [15:0] m_idx [NQ];
  logic [7:0]  m_lim [2048];
  logic [7:0]  m_cnt [2048];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bemask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req && mem_we) begin
        if (exp_q.size() == 0) begin
          check(0, "R1/R7 unexpected write", {9'd0, mem_addr, mem_wdata}, 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.addr && mem_be == e.be && wake == e.wk &&
                (mem_wdata & bemask(e.be)) == (e.data & bemask(e.be)),
                e.tag, {mem_be, 1'b0, wake, mem_addr, mem_wdata},
                {e.be, 1'b0, e.wk, e.addr, e.data});
        end
      end else if (wake) begin
        check(0, "R8 wake without data write", 64'd1, 64'd0);
      end
    end
  end

  task automatic set_pair(input int pg, input logic [7:0] lim, input logic [7:0] cnt);
    logic [MEM_AW-1:0] a;
    logic [31:0] w;
    a = (TOP + MEM_AW'(2*pg)) & ~MEM_AW'(3);
    w = bmem.exists(32'(a >> 2)) ? bmem[32'(a >> 2)] : 32'h0;
    w[16*(pg & 1) +: 16] = {cnt, lim};
    bmem[32'(a >> 2)] = w;
    m_lim[pg] = lim;
    m_cnt[pg] = cnt;
  endtask

  task automatic model(input logic [23:0] a, input logic [31:0] d, input string tag);
    int q, pg;
    logic [MEM_AW-1:0] rb;
    exp_t e;
    if (a < 24'h808000) return;
    q  = cfg_multi ? int'(a[22:21]) : 0;
    pg = int'(a[22:12]);
    if (cfg_limit) begin
      if (m_cnt[pg] == m_lim[pg]) return;
      m_cnt[pg] = m_cnt[pg] + 8'd1;
      e.addr = (TOP + MEM_AW'(2*pg)) & ~MEM_AW'(3);
      e.be   = (pg & 1) ? 4'b1000 : 4'b0010;
      e.data = {4{m_cnt[pg]}};
      e.wk   = 0;
      e.tag  = {"R6 count writeback ", tag};
      exp_q.push_back(e);
    end
    rb = base[q*MEM_AW +: MEM_AW] + MEM_AW'({m_idx[q], 3'b000});
    e.addr = rb; e.be = 4'hF; e.data = {8'h00, a[23:2], 2'b00}; e.wk = 0;
    e.tag = {"R2 address word ", tag};
    exp_q.push_back(e);
    e.addr = rb + MEM_AW'(4); e.data = d; e.wk = 1;
    e.tag = {"R8 data word ", tag};
    exp_q.push_back(e);
    m_idx[q] = (m_idx[q] + 16'd1) & 16'((32'd512 << cfg_size) - 1);
  endtask

  task automatic hw_write(input logic [23:0] a, input logic [31:0] d, input string tag);
    bit r;
    @(negedge clk);
    hw_valid = 1; hw_addr = a; hw_data = d;
    model(a, d, tag);
    forever begin
      r = hw_ready;
      @(posedge clk);
      if (r) break;
    end
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    hw_valid = 0;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic cfg_pulse();
    @(negedge clk);
    cfg_we = 1;
    for (int i = 0; i < NQ; i++) m_idx[i] = '0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  int stall_cycles = 0;
  always @(negedge clk) if (rst_n && hw_valid && !hw_ready) stall_cycles++;

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) m_idx[i] = '0;
    for (int i = 0; i < 2048; i++) begin m_lim[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check(hw_ready == 1 && mem_req == 0 && wake == 0, "R11 reset state",
          {61'd0, hw_ready, mem_req, wake}, 64'h4);
    rst_n = 1;

    // single queue, basic capture and window edges
    cfg_size = 3'd0; cfg_multi = 0; cfg_limit = 0;
    base[0 +: MEM_AW] = 23'h010000;
    cfg_pulse();
    hw_write(24'h800040, 32'hDEAD0001, "R1 below window");
    hw_write(24'h807FFC, 32'hDEAD0002, "R1 just below window");
    hw_write(24'h808000, 32'hA0000001, "R1 window low edge");
    hw_write(24'h8A1236, 32'hA0000002, "R2 unaligned low bits");
    hw_write(24'hFFFFFC, 32'hA0000003, "R1 window high edge");
    hw_write(24'h012340, 32'hDEAD0003, "R1 memory space ignored");
    drain("R1 R2 drain");

    // wrap of a 512-entry queue
    for (int i = 3; i < 513; i++) hw_write(24'h900000 + 24'(i*4), 32'hB0000000 + i, "R3 wrap sweep");
    drain("R3 wrap drain");

    // four queues, size 1
    cfg_size = 3'd1; cfg_multi = 1;
    base[0*MEM_AW +: MEM_AW] = 23'h020000;
    base[1*MEM_AW +: MEM_AW] = 23'h040000;
    base[2*MEM_AW +: MEM_AW] = 23'h060000;
    base[3*MEM_AW +: MEM_AW] = 23'h080000;
    cfg_pulse();
    hw_write(24'h808000, 32'hC0000000, "R9 R4 queue0 after clear");
    hw_write(24'hA00000, 32'hC0000001, "R4 queue1");
    hw_write(24'hC00010, 32'hC0000002, "R4 queue2");
    hw_write(24'hE00020, 32'hC0000003, "R4 queue3");
    hw_write(24'hBFFFFC, 32'hC0000004, "R4 queue1 second");
    drain("R4 drain");

    // credit check
    cfg_multi = 0; cfg_limit = 1; cfg_size = 3'd2;
    base[0 +: MEM_AW] = 23'h100000;
    cfg_pulse();
    set_pair(9, 8'd2, 8'd0);
    set_pair(10, 8'd0, 8'd0);
    set_pair(12, 8'd5, 8'd4);
    set_pair(13, 8'h80, 8'hFE);
    hw_write(24'h809000, 32'hD0000001, "R5 odd page credit");
    hw_write(24'h809004, 32'hD0000002, "R6 odd page credit");
    hw_write(24'h809008, 32'hD0000003, "R7 odd page exhausted");
    hw_write(24'h80A000, 32'hD0000004, "R7 zero limit");
    hw_write(24'h80C000, 32'hD0000005, "R5 even page credit");
    hw_write(24'h80C004, 32'hD0000006, "R7 even page exhausted");
    hw_write(24'h80D000, 32'hD0000007, "R6 count rollover");
    hw_write(24'h80D004, 32'hD0000008, "R6 count wraps to zero");
    drain("R5 R6 R7 drain");

    // back-to-back burst through the buffer
    cfg_limit = 0;
    stall_cycles = 0;
    for (int i = 0; i < 6; i++) hw_write(24'h810000 + 24'(i*8), 32'hE0000000 + i, "R10 burst");
    check(stall_cycles > 0, "R10 ready low when full", 64'(stall_cycles), 64'd1);
    drain("R10 burst drain");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule